// File: doc/BRIEF.md
# Interrupt Acceptance Gate

This block sits between the interrupt priority logic and the CPU sequencer. It picks the cycle on which a pending interrupt may be taken. Two kinds of request arrive. One is a maskable request, a level held by the source. The other is a non-maskable request (NMI), which is detected on its rising edge. The execution unit sends strobes that mark where acceptance is legal. An instruction-boundary strobe comes with the class of the retiring instruction. A transfer-step strobe marks a boundary between the cycles of a block transfer, and two status bits give whether a block transfer is running and whether it moves words or bytes.

Both kinds of request are captured into pending latches, so a request that appears only briefly is still taken later. Acceptance is held off in three cases:
- at the boundary of an instruction that rewrites the interrupt mask;
- for every request during a byte-sized block transfer;
- for maskable requests during a word-sized block transfer.

During a word-sized transfer an NMI is taken at the next transfer step. The block gives a one-cycle accept pulse, a vector-type bit and the return address the sequencer must push.

Top module: `irq_gate`

## Requirements
- R1: While rst_ni is low, accept_o, vec_nmi_o and ret_addr_o are zero. Reset clears both pending latches and the mask-change inhibit. After reset no accept occurs until a new request arrives, and an NMI at a word transfer step is not blocked by an inhibit from before reset.
- R2: An accept happens only on one of two strobes. The first is boundary_i with xfer_active_i low. The second is xfer_step_i with xfer_active_i and xfer_word_i high. accept_o rises on the clock edge that samples the strobe and is high for exactly that one cycle.
- R3: A maskable request is accepted only when mask_i is 0. A mask_i of 1 never blocks an NMI.
- R4: At a boundary_i where retire_cls_i is 2'b01 (mask-modifying instruction), nothing is accepted. At the next boundary of any other class, acceptance is allowed again.
- R5: After a mask-modifying boundary, the inhibit lasts until the next boundary_i outside a transfer. An NMI is therefore not taken at word-transfer steps that fall inside that following instruction.
- R6: While xfer_active_i is high and xfer_word_i is 0 (byte transfer), nothing is accepted, NMI included. Pending requests are taken at the boundary that ends the transfer.
- R7: While a word transfer is active, maskable requests are held. A pending NMI is accepted at the next xfer_step_i.
- R8: ret_addr_o on an accept equals pc_next_i sampled with the accepting strobe. The mid-transfer NMI case is included.
- R9: If irq_req_i is high for even one cycle, the maskable pending latch is set. The request is honoured at a later eligible boundary even after irq_req_i has dropped. The latch clears on acceptance.
- R10: A rising edge on nmi_i sets the NMI pending latch. The latch holds through any number of blocked cycles, and acceptance clears it. Holding nmi_i high does not make a second request.
- R11: When both requests are eligible, the NMI is accepted first with vec_nmi_o = 1. The maskable request stays pending and is accepted later with vec_nmi_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Maskable request, level from priority logic |
| mask_i | input | 1 | Interrupt mask flag, 1 = maskable blocked |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| boundary_i | input | 1 | Instruction-boundary strobe |
| retire_cls_i | input | 2 | Class of retiring instruction, 2'b01 = mask-modifying |
| xfer_active_i | input | 1 | Block transfer in progress |
| xfer_word_i | input | 1 | Block transfer element size, 1 = word, 0 = byte |
| xfer_step_i | input | 1 | Boundary between transfer cycles |
| pc_next_i | input | PC_W | Address of the next instruction |
| accept_o | output | 1 | One-cycle accept pulse |
| vec_nmi_o | output | 1 | Vector type of the accept, 1 = NMI |
| ret_addr_o | output | PC_W | Return address to push |

## Verification
All three outputs are registered, and they are set by the same clock edge that samples an accepting strobe. The bench drives inputs on the falling edge and reads the outputs 2 ns after the following rising edge.

A request needs one edge to reach its pending latch before any strobe can use it. So each case applies the request in one cycle and the strobe in a later cycle. It also checks for silence between the two.

The sweep resets the block before every one of its 64 configurations. That way no latch or inhibit state is carried from one case into the next.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  typedef enum logic [1:0] {
    CLS_PLAIN   = 2'b00,
    CLS_MASKMOD = 2'b01,
    CLS_XFER    = 2'b10,
    CLS_OTHER   = 2'b11
  } retire_cls_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic take_i,
  output logic pend_o
);
  logic set;
  logic pend_q;

  generate
    if (EDGE) begin : g_edge
      logic req_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= 1'b0;
        else         req_q <= req_i;
      end
      assign set = req_i & ~req_q;
    end else begin : g_level
      assign set = req_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~take_i) | set;
  end

  assign pend_o = pend_q;

  // R9 R10
  pend_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set |=> pend_o);

  // R10
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !take_i) |=> pend_o);
endmodule

// File: rtl/irq_inhibit.sv
module irq_inhibit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boundary_i,
  input  logic xfer_active_i,
  input  logic maskmod_i,
  output logic inh_o
);
  logic inh_q;

  // flag spans exactly the instruction after a mask change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         inh_q <= 1'b0;
    else if (boundary_i && !xfer_active_i) inh_q <= maskmod_i;
  end

  assign inh_o = inh_q;

  // R4 R5
  inh_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !xfer_active_i && maskmod_i) |=> inh_o);

  // R5
  inh_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(boundary_i && !xfer_active_i)) |=> $stable(inh_o));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_req_i,
  input  logic            mask_i,
  input  logic            nmi_i,
  input  logic            boundary_i,
  input  logic [1:0]      retire_cls_i,
  input  logic            xfer_active_i,
  input  logic            xfer_word_i,
  input  logic            xfer_step_i,
  input  logic [PC_W-1:0] pc_next_i,
  output logic            accept_o,
  output logic            vec_nmi_o,
  output logic [PC_W-1:0] ret_addr_o
);
  logic maskmod, inh, nmi_pend, irq_pend;
  logic bnd_ok, step_ok, take_nmi, take_irq;

  assign maskmod = (retire_cls_e'(retire_cls_i) == CLS_MASKMOD);

  irq_pend #(.EDGE(1'b1)) u_nmi_pend (
    .clk_i, .rst_ni, .req_i(nmi_i), .take_i(take_nmi), .pend_o(nmi_pend)
  );

  irq_pend #(.EDGE(1'b0)) u_irq_pend (
    .clk_i, .rst_ni, .req_i(irq_req_i), .take_i(take_irq), .pend_o(irq_pend)
  );

  irq_inhibit u_inhibit (
    .clk_i, .rst_ni, .boundary_i, .xfer_active_i, .maskmod_i(maskmod), .inh_o(inh)
  );

  assign bnd_ok   = boundary_i & ~xfer_active_i & ~maskmod;
  assign step_ok  = xfer_active_i & xfer_word_i & xfer_step_i & ~inh;
  assign take_nmi = nmi_pend & (bnd_ok | step_ok);
  assign take_irq = irq_pend & ~mask_i & bnd_ok & ~take_nmi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o   <= 1'b0;
      vec_nmi_o  <= 1'b0;
      ret_addr_o <= '0;
    end else begin
      accept_o  <= take_nmi | take_irq;
      vec_nmi_o <= take_nmi;
      if (take_nmi | take_irq) ret_addr_o <= pc_next_i;
    end
  end

  // R3
  mask_respect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !vec_nmi_o) |-> $past(!mask_i));

  // R2
  strobe_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> ($past(boundary_i && !xfer_active_i) ||
                  $past(xfer_step_i && xfer_active_i && xfer_word_i)));

  // R4
  maskmod_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !xfer_active_i && maskmod) |=> !accept_o);

  // R6
  byte_xfer_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_active_i && !xfer_word_i) |=> !accept_o);

  // R7
  word_xfer_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_active_i |=> (!accept_o || vec_nmi_o));

  // R8
  ret_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (ret_addr_o == $past(pc_next_i)));
endmodule

// File: tb/irq_gate_tb.sv
module irq_gate_tb;
  localparam int PC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0, mask = 1'b0, nmi = 1'b0, bnd = 1'b0;
  logic [1:0] cls = 2'b00;
  logic xa = 1'b0, xw = 1'b0, xs = 1'b0;
  logic [PC_W-1:0] pc = '0;
  logic acc, vnmi;
  logic [PC_W-1:0] ret;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_gate #(.PC_W(PC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq), .mask_i(mask), .nmi_i(nmi),
    .boundary_i(bnd), .retire_cls_i(cls), .xfer_active_i(xa), .xfer_word_i(xw),
    .xfer_step_i(xs), .pc_next_i(pc), .accept_o(acc), .vec_nmi_o(vnmi),
    .ret_addr_o(ret)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk); #2;
  endtask

  task automatic quiet();
    @(negedge clk);
    irq = 0; nmi = 0; bnd = 0; cls = 2'b00; xs = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; irq = 0; mask = 0; nmi = 0; bnd = 0; cls = 0; xa = 0; xw = 0; xs = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // one strobe cycle, result checked after the sampling edge
  task automatic strobe(logic b, logic s, logic [1:0] c, logic [PC_W-1:0] p);
    @(negedge clk);
    bnd = b; xs = s; cls = c; pc = p;
    edge_wait();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk); irq = 1; nmi = 1; bnd = 1;
    edge_wait();
    check("R1 acc in reset", acc, 0);
    check("R1 vec in reset", vnmi, 0);
    check("R1 ret in reset", ret, 0);

    // R1 inhibit cleared by reset
    do_reset();
    strobe(1, 0, 2'b01, 16'h0100);
    do_reset();
    @(negedge clk); nmi = 1; edge_wait(); quiet();
    @(negedge clk); xa = 1; xw = 1;
    strobe(0, 1, 2'b00, 16'h0202);
    check("R1 inhibit cleared", acc, 1);
    check("R1 nmi vector", vnmi, 1);
    quiet(); xa = 0; xw = 0;
    strobe(1, 0, 2'b00, 16'h0203);
    check("R1 no stale accept", acc, 0);

    // sweep: pending set, then one strobe in each configuration
    for (int c = 0; c < 64; c++) begin
      logic np, ip, mk, mm, a, w, en, ei;
      logic [PC_W-1:0] p;
      np = c[0]; ip = c[1]; mk = c[2]; mm = c[3]; a = c[4]; w = c[5];
      p = PC_W'(16'h1000 + c * 7);
      do_reset();
      @(negedge clk); nmi = np; irq = ip; edge_wait();
      check("R2 no strobe no accept", acc, 0);
      quiet();
      mask = mk; xa = a; xw = w;
      strobe(!a, a, mm ? 2'b01 : 2'b00, p);
      en = np & ((!a & !mm) | (a & w));
      ei = ip & !mk & !a & !mm & !en;
      check("R2 R3 R4 R6 R7 sweep accept", acc, en | ei);
      if (en | ei) begin
        check("R11 sweep vector", vnmi, en);
        check("R8 sweep return", ret, p);
      end
      quiet(); bnd = 0; xs = 0;
      edge_wait();
      check("R2 single-cycle pulse", acc, 0);
      mask = 0; xa = 0; xw = 0;
    end

    // R4 mask-modifying boundary then plain boundary
    do_reset();
    @(negedge clk); irq = 1; edge_wait(); quiet();
    strobe(1, 0, 2'b01, 16'h2000);
    check("R4 blocked at mask change", acc, 0);
    quiet();
    strobe(1, 0, 2'b00, 16'h2002);
    check("R4 accepted next boundary", acc, 1);
    check("R4 maskable vector", vnmi, 0);

    // R5 inhibit spans a following word transfer
    do_reset();
    strobe(1, 0, 2'b01, 16'h3000);
    quiet();
    @(negedge clk); nmi = 1; edge_wait(); quiet();
    xa = 1; xw = 1;
    for (int i = 0; i < 3; i++) begin
      strobe(0, 1, 2'b00, 16'h3004);
      check("R5 step blocked by inhibit", acc, 0);
      quiet();
    end
    xa = 0; xw = 0;
    strobe(1, 0, 2'b10, 16'h3004);
    check("R5 accepted at transfer end", acc, 1);
    check("R5 nmi vector", vnmi, 1);
    check("R8 return after transfer", ret, 16'h3004);

    // R6 byte transfer holds NMI to the end
    do_reset();
    @(negedge clk); nmi = 1; edge_wait(); quiet();
    xa = 1; xw = 0;
    for (int i = 0; i < 4; i++) begin
      strobe(0, 1, 2'b00, 16'h4006);
      check("R6 byte transfer held", acc, 0);
      quiet();
    end
    xa = 0;
    strobe(1, 0, 2'b10, 16'h4006);
    check("R6 taken at transfer end", acc, 1);
    check("R6 nmi vector", vnmi, 1);

    // R7 word transfer: maskable held, NMI mid-transfer; R8 next address
    do_reset();
    @(negedge clk); irq = 1; edge_wait(); quiet();
    xa = 1; xw = 1;
    strobe(0, 1, 2'b00, 16'h500A);
    check("R7 maskable held in word xfer", acc, 0);
    quiet();
    @(negedge clk); nmi = 1; edge_wait(); quiet();
    strobe(0, 1, 2'b00, 16'h500A);
    check("R7 nmi at transfer step", acc, 1);
    check("R7 nmi vector", vnmi, 1);
    check("R8 mid-transfer return", ret, 16'h500A);
    quiet(); xa = 0; xw = 0;
    strobe(1, 0, 2'b10, 16'h500A);
    check("R7 maskable after transfer", acc, 1);
    check("R7 maskable vector", vnmi, 0);

    // R9 brief request survives, R3 mask holds it
    do_reset();
    @(negedge clk); irq = 1; edge_wait(); quiet();
    repeat (3) edge_wait();
    mask = 1;
    strobe(1, 0, 2'b00, 16'h6000);
    check("R3 masked boundary", acc, 0);
    quiet(); mask = 0;
    strobe(1, 0, 2'b00, 16'h6002);
    check("R9 dropped request honoured", acc, 1);
    quiet();
    strobe(1, 0, 2'b00, 16'h6004);
    check("R9 latch cleared on accept", acc, 0);

    // R10 held-high NMI is one request; R3 mask ignored for NMI
    do_reset();
    @(negedge clk); nmi = 1; mask = 1;
    repeat (4) edge_wait();
    strobe(1, 0, 2'b00, 16'h7000);
    check("R10 held nmi taken", acc, 1);
    check("R3 nmi despite mask", vnmi, 1);
    @(negedge clk); bnd = 0;
    strobe(1, 0, 2'b00, 16'h7002);
    check("R10 no re-trigger on level", acc, 0);
    quiet(); mask = 0;

    // R11 both eligible
    do_reset();
    @(negedge clk); nmi = 1; irq = 1; edge_wait(); quiet();
    strobe(1, 0, 2'b00, 16'h8000);
    check("R11 nmi first", vnmi, 1);
    check("R11 accept", acc, 1);
    quiet();
    strobe(1, 0, 2'b00, 16'h8002);
    check("R11 maskable second", acc, 1);
    check("R11 maskable vector", vnmi, 0);
    check("R8 second return", ret, 16'h8002);
    quiet();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule